// File: doc/BRIEF.md
# FSK Manchester Credential Modulator

This block produces the load-modulation waveform of a 44-bit low-frequency proximity credential, so that a chip can stand in for a tag. It runs on the carrier clock and drives a single modulation line. Each frame begins with a fixed run of eight tone groups, and that run contains Manchester pairs that are not valid data, so a reader can find where the frame starts. The 44 ID bits follow, each sent as two tone groups. A tone group is a square wave with a subcarrier period of either 8 or 10 carrier clocks. It is repeated enough times that both kinds of group last about 50 clocks.

Software loads the ID as a 12-bit upper part and a 32-bit lower part, using a 16-bit upper input. A load whose upper part has any bit set above bit 11 is refused, and an error pulse is raised. An accepted ID is held pending and becomes active only when the next frame begins, so no frame ever mixes two IDs. While enable is high the frame repeats without a gap. Dropping enable forces the line low and rewinds the sequence to the start of the frame.

Top module: `fsk_credential_modulator`

## Requirements
- R1: While rst_n is low, or in any cycle after a clock edge that sampled enable low, mod_out and frame_start are 0. The first clock edge that samples enable high after it was low makes frame_start 1 in the following cycle, and the frame restarts from its first group.
- R2: A tone group of period P is P/2 cycles of mod_out high followed by P/2 cycles low. That pattern repeats 6 times when P is 8 and 5 times when P is 10, so the groups last 48 and 50 cycles.
- R3: A frame opens with eight groups whose periods are, in time order, 8, 8, 8, 10, 10, 10, 8, 10. This preamble takes 392 cycles.
- R4: A data bit of 1 is sent as a period-10 group and then a period-8 group. A data bit of 0 is sent as a period-8 group and then a period-10 group.
- R5: After the preamble, the bits are sent from ID bit 43 down to bit 0. ID bits 43..32 are id_hi[11:0] and bits 31..0 are id_lo. One frame is 4704 cycles, and the next frame follows at once.
- R6: frame_start is 1 for exactly the first cycle of each frame and is 0 in every other cycle.
- R7: A load with any of id_hi[15:12] set is rejected. load_err is 1 in the single cycle after that load, and the transmitted ID does not change. An accepted load leaves load_err at 0.
- R8: An accepted load does not change the frame in progress. The new ID is transmitted from the next frame onward.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Carrier-rate clock |
| rst_n | input | 1 | Synchronous reset, active low |
| enable | input | 1 | Run the frame loop; low holds the line low and rewinds |
| id_load | input | 1 | One-cycle strobe that offers id_hi/id_lo |
| id_hi | input | 16 | Upper ID part; only bits 11..0 may be set |
| id_lo | input | 32 | Lower 32 ID bits |
| mod_out | output | 1 | Modulation line |
| frame_start | output | 1 | High on the first cycle of each frame |
| load_err | output | 1 | One-cycle pulse after a rejected load |

## Verification
The bench drives inputs on the falling clock edge and samples on the falling edge. Every result is therefore read half a cycle after the rising edge that produced it. frame_start and the first high cycle of mod_out are due one cycle after the edge that first samples enable high, and the line goes low one cycle after enable is sampled low. load_err is due one cycle after the load and must be gone one cycle later. A load made partway through a frame is checked against the remainder of that same frame, which must still carry the old ID, and the new ID is expected from the next frame_start. Each frame is compared cycle by cycle with a waveform the bench builds from the group rules, with the preamble, the first group, the data and the frame_start positions each counted as a separate check.

// File: rtl/fskm_pkg.sv
// Package: fskm_pkg
// Holds the constants shared by the modulator's submodules.
// Assumes the preamble is always eight groups long.
package fskm_pkg;
    // Number of tone groups in the start-of-frame marker
    localparam int PRE_N = 8;
    // Bit g set means preamble group g (in time order) uses the long period
    localparam logic [PRE_N-1:0] PRE_LONG_MAP = 8'b1011_1000;

    typedef enum logic { TONE_SHORT = 1'b0, TONE_LONG = 1'b1 } tone_e;
endpackage

// File: rtl/fskm_id_latch.sv
// Module: fskm_id_latch
// Checks an offered ID, keeps it pending and copies it into the active
// register only on the cycle the sequencer marks as the frame boundary.
// Assumes id_load is a one-cycle strobe. A load refused for a too-wide
// upper part leaves the pending value untouched.
module fskm_id_latch #(
    parameter int HI_IN_W = 16,
    parameter int HI_W    = 12,
    parameter int LO_W    = 32,
    localparam int ID_W   = HI_W + LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               id_load,
    input  logic [HI_IN_W-1:0] id_hi,
    input  logic [LO_W-1:0]    id_lo,
    input  logic               frame_next,
    output logic [ID_W-1:0]    active_id,
    output logic               load_err
);
    logic            too_wide;
    logic [ID_W-1:0] pending_id;

    // Width check exists only when the input is wider than the ID part
    generate
        if (HI_IN_W > HI_W) begin : g_wide_chk
            assign too_wide = |id_hi[HI_IN_W-1:HI_W];
        end else begin : g_no_chk
            assign too_wide = 1'b0;
        end
    endgenerate

    // Capture accepted loads and flag refused ones for one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pending_id <= '0;
            load_err   <= 1'b0;
        end else begin
            load_err <= id_load && too_wide;
            if (id_load && !too_wide)
                pending_id <= {id_hi[HI_W-1:0], id_lo};
        end
    end

    // Promote the pending ID only on a frame boundary
    always_ff @(posedge clk) begin
        if (!rst_n)
            active_id <= '0;
        else if (frame_next)
            active_id <= pending_id;
    end

    // R7: a wide load yields an error pulse on the next cycle
    p_reject_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (id_load && too_wide) |=> load_err);

    // R8: the transmitted ID moves only across a frame boundary
    p_active_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !frame_next |=> $stable(active_id));
endmodule

// File: rtl/fskm_tone_gen.sv
// Module: fskm_tone_gen
// Produces one tone group at a time: a square wave of the selected period,
// high for the first half, repeated a per-period number of times. Reports
// the last cycle of the group and the first cycle of the group.
// Assumes both periods are even and tone_long is steady within a group.
module fskm_tone_gen #(
    parameter int P_SHORT   = 8,
    parameter int P_LONG    = 10,
    parameter int REP_SHORT = 6,
    parameter int REP_LONG  = 5,
    localparam int PMAX     = (P_LONG > P_SHORT) ? P_LONG : P_SHORT,
    localparam int RMAX     = (REP_LONG > REP_SHORT) ? REP_LONG : REP_SHORT,
    localparam int PW       = $clog2(PMAX + 1),
    localparam int RW       = $clog2(RMAX + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic run,
    input  logic tone_long,
    output logic level,
    output logic group_first,
    output logic group_done
);
    logic [PW-1:0] ph;
    logic [RW-1:0] rep;
    logic [PW-1:0] period;
    logic [RW-1:0] reps;

    // Select the period and repeat count of the current group
    always_comb begin
        period = tone_long ? PW'(P_LONG)   : PW'(P_SHORT);
        reps   = tone_long ? RW'(REP_LONG) : RW'(REP_SHORT);
    end

    assign group_done  = run && (ph == period - 1'b1) && (rep == reps - 1'b1);
    assign group_first = (ph == '0) && (rep == '0);
    assign level       = run && (ph < (period >> 1));

    // Step the phase within a cycle and the repeat count within a group
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            ph  <= '0;
            rep <= '0;
        end else if (run) begin
            if (ph == period - 1'b1) begin
                ph  <= '0;
                rep <= (rep == reps - 1'b1) ? '0 : rep + 1'b1;
            end else begin
                ph <= ph + 1'b1;
            end
        end
    end

    // R2: the phase never leaves the current period
    p_phase_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (ph < period));
endmodule

// File: rtl/fskm_group_seq.sv
// Module: fskm_group_seq
// Walks the groups of a frame. It covers the preamble first, then two groups
// per ID bit from the top bit down, and decides for each group whether the
// long or the short period is used. It also owns the run flag.
// Assumes active_id only changes while frame_next is high.
module fskm_group_seq
    import fskm_pkg::*;
#(
    parameter int ID_W  = 44,
    localparam int NGRP = PRE_N + 2 * ID_W,
    localparam int GW   = $clog2(NGRP + 1),
    localparam int IW   = $clog2(ID_W)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            enable,
    input  logic            group_done,
    input  logic [ID_W-1:0] active_id,
    output logic            run,
    output logic            first_group,
    output logic            frame_next,
    output tone_e           tone
);
    logic [GW-1:0] grp;
    logic [GW-1:0] dpos;
    logic [IW-1:0] bit_idx;
    logic          data_bit;
    logic          last_grp;

    assign last_grp    = (grp == GW'(NGRP - 1));
    assign first_group = (grp == '0);
    assign frame_next  = !run || (last_grp && group_done);

    // Map the group index to a period: table for the preamble, Manchester for data
    always_comb begin
        dpos     = grp - GW'(PRE_N);
        bit_idx  = IW'(ID_W - 1) - IW'(dpos >> 1);
        data_bit = active_id[bit_idx];
        if (grp < GW'(PRE_N))
            tone = tone_e'(PRE_LONG_MAP[grp[2:0]]);
        else
            tone = tone_e'(data_bit ^ dpos[0]);
    end

    // Track enable and advance the group index at each group end
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run <= 1'b0;
            grp <= '0;
        end else begin
            run <= enable;
            if (!enable)
                grp <= '0;
            else if (run && group_done)
                grp <= last_grp ? '0 : grp + 1'b1;
        end
    end

    // R5: the group index stays inside one frame
    p_grp_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        grp < GW'(NGRP));
endmodule

// File: rtl/fsk_credential_modulator.sv
// Module: fsk_credential_modulator
// Top level. Sends a repeating frame, made of a preamble and 44
// Manchester-coded ID bits, as FSK tone groups on mod_out.
// Assumes clk is the carrier clock and id_load is a one-cycle strobe.
module fsk_credential_modulator #(
    parameter int HI_IN_W   = 16,
    parameter int HI_W      = 12,
    parameter int LO_W      = 32,
    parameter int P_SHORT   = 8,
    parameter int P_LONG    = 10,
    parameter int REP_SHORT = 6,
    parameter int REP_LONG  = 5,
    localparam int ID_W     = HI_W + LO_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               enable,
    input  logic               id_load,
    input  logic [HI_IN_W-1:0] id_hi,
    input  logic [LO_W-1:0]    id_lo,
    output logic               mod_out,
    output logic               frame_start,
    output logic               load_err
);
    import fskm_pkg::*;

    logic            run;
    logic            first_group;
    logic            frame_next;
    logic            group_done;
    logic            group_first;
    logic [ID_W-1:0] active_id;
    tone_e           tone;

    fskm_id_latch #(.HI_IN_W(HI_IN_W), .HI_W(HI_W), .LO_W(LO_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .id_load(id_load), .id_hi(id_hi),
        .id_lo(id_lo), .frame_next(frame_next), .active_id(active_id),
        .load_err(load_err)
    );

    fskm_group_seq #(.ID_W(ID_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .group_done(group_done),
        .active_id(active_id), .run(run), .first_group(first_group),
        .frame_next(frame_next), .tone(tone)
    );

    fskm_tone_gen #(.P_SHORT(P_SHORT), .P_LONG(P_LONG),
                    .REP_SHORT(REP_SHORT), .REP_LONG(REP_LONG)) u_tone (
        .clk(clk), .rst_n(rst_n), .enable(enable), .run(run),
        .tone_long(tone == TONE_LONG), .level(mod_out),
        .group_first(group_first), .group_done(group_done)
    );

    assign frame_start = run && first_group && group_first;

    // R1: a low enable silences the line on the next cycle
    p_low_when_disabled_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!mod_out && !frame_start));

    // R6: re-enabling restarts at the first cycle of a frame
    p_restart_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable ##1 enable) |=> frame_start);

    // R2: every frame starts on the high half of a tone cycle
    p_start_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> mod_out);
endmodule

// File: tb/tb_fsk_credential_modulator.sv
module tb_fsk_credential_modulator;
    localparam int FRAME_LEN = 4 * 48 + 4 * 50 + 44 * 98;
    localparam int PRE_LEN   = 392;
    localparam int NV        = 6;
    // Fields: {reject expected, id_hi[15:0], id_lo[31:0]}
    localparam logic [48:0] VEC [NV] = '{
        {1'b0, 16'h0A5C, 32'h1234_5678},
        {1'b0, 16'h0FFF, 32'hFFFF_FFFF},
        {1'b1, 16'h1ABC, 32'hDEAD_BEEF},
        {1'b0, 16'h0800, 32'h0000_0001},
        {1'b1, 16'h8000, 32'h0000_0000},
        {1'b0, 16'h0000, 32'h8000_0000}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic        id_load = 1'b0;
    logic [15:0] id_hi = '0;
    logic [31:0] id_lo = '0;
    logic        mod_out, frame_start, load_err;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;
    logic exp_w [FRAME_LEN];
    logic [43:0] cur;

    always #4 clk = ~clk;

    fsk_credential_modulator dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .id_load(id_load),
        .id_hi(id_hi), .id_lo(id_lo), .mod_out(mod_out),
        .frame_start(frame_start), .load_err(load_err)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Expected waveform from the group rules (R2..R5)
    task automatic build_exp(input logic [43:0] id);
        int t = 0;
        bit pre [8] = '{0, 0, 0, 1, 1, 1, 0, 1};
        for (int g = 0; g < 96; g++) begin
            bit lng;
            int p, r;
            if (g < 8) lng = pre[g];
            else if (id[43 - (g - 8) / 2]) lng = ((g - 8) % 2 == 0);
            else lng = ((g - 8) % 2 == 1);
            p = lng ? 10 : 8;
            r = lng ? 5 : 6;
            for (int k = 0; k < r * p; k++) begin
                exp_w[t] = ((k % p) < p / 2);
                t++;
            end
        end
    endtask

    // Check one full frame; optionally offer a load partway through it
    task automatic check_frame(input logic [43:0] id, input bit do_load,
                               input logic [15:0] lh, input logic [31:0] ll,
                               input bit lerr);
        int wait_n = 0;
        int e_first = -1, e_pre = -1, e_data = -1, e_fs = -1;
        build_exp(id);
        while (!frame_start && wait_n < 10000) begin
            @(negedge clk);
            wait_n++;
        end
        chk(frame_start == 1'b1, "R6 frame_start found", frame_start, 1);
        for (int t = 0; t < FRAME_LEN; t++) begin
            if (t > 0) @(negedge clk);
            if (mod_out !== exp_w[t]) begin
                if (t < 48) begin if (e_first < 0) e_first = t; end
                else if (t < PRE_LEN) begin if (e_pre < 0) e_pre = t; end
                else if (e_data < 0) e_data = t;
            end
            if (frame_start !== (t == 0) && e_fs < 0) e_fs = t;
            if (do_load && t == 2000) begin
                id_load = 1'b1; id_hi = lh; id_lo = ll;
            end
            if (do_load && t == 2001) begin
                id_load = 1'b0;
                chk(load_err == lerr, "R7 load_err after load", load_err, lerr);
            end
            if (do_load && t == 2002)
                chk(load_err == 1'b0, "R7 load_err one cycle", load_err, 0);
        end
        chk(e_first < 0, "R2 first group shape, mismatch cycle", e_first, -1);
        chk(e_pre < 0, "R3 preamble, mismatch cycle", e_pre, -1);
        chk(e_data < 0, "R4 R5 R8 data bits, mismatch cycle", e_data, -1);
        chk(e_fs < 0, "R6 frame_start position", e_fs, -1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(mod_out == 1'b0, "R1 mod_out in reset", mod_out, 0);
        chk(frame_start == 1'b0, "R1 frame_start in reset", frame_start, 0);
        chk(load_err == 1'b0, "R1 load_err in reset", load_err, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(mod_out == 1'b0, "R1 idle with enable low", mod_out, 0);
        enable = 1'b1;
        @(negedge clk);
        chk(frame_start == 1'b1, "R1 start one cycle after enable", frame_start, 1);
        cur = '0;
        // Table walk: each load is offered mid-frame against the current ID (R8)
        for (int i = 0; i < NV; i++) begin
            check_frame(cur, 1'b1, VEC[i][47:32], VEC[i][31:0], VEC[i][48]);
            if (!VEC[i][48]) cur = {VEC[i][43:32], VEC[i][31:0]};
        end
        check_frame(cur, 1'b0, '0, '0, 1'b0);
        // Directed: drop enable mid-frame, then resume at the preamble (R1)
        repeat (300) @(negedge clk);
        enable = 1'b0;
        begin
            int hi_seen = 0;
            for (int k = 0; k < 20; k++) begin
                @(negedge clk);
                if (mod_out || frame_start) hi_seen++;
            end
            chk(hi_seen == 0, "R1 line low while disabled", hi_seen, 0);
        end
        enable = 1'b1;
        @(negedge clk);
        chk(frame_start == 1'b1, "R1 restart at preamble", frame_start, 1);
        check_frame(cur, 1'b0, '0, '0, 1'b0);
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule